// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Memory Write Controller

This block is the control side of a byte-wide parallel nonvolatile memory that is written a page at a time. A host drives an address, a data byte and three active-low strobes (chip enable, output enable, write enable). The block samples them on its own clock. A write strobe ends in a byte load. Loaded bytes collect in a page register while a load-window timer runs. When the window runs out, a self-timed commit copies every loaded byte into the storage array, which is modelled as a plain register file. At the end of the commit the page register clears itself.

While a window or commit is open, reads return status instead of stored data. Bit 7 is the complement of bit 7 of the last byte loaded. Bit 6 changes on every new read. A host can therefore poll for completion. Writes can be blocked by a hardware inhibit input. They can also be blocked by a software protection mode, which is switched on and off by short command sequences of address/data loads.

The address splits into a row (upper bits) and a column (the low `COL_W` bits). The default size is small so that it elaborates quickly. Setting `ADDR_W` to 15 with `COL_W` at 6 gives a 32K x 8 array with 64-byte pages.

Top module: `eep_page_ctrl`

## Requirements
- R1: A committed byte is stored at array address {row latched with the first load of the window, column = low COL_W bits of its own load address}. When no window or commit is open, a read of that address returns the byte.
- R2: A load uses the address and data sampled in the last cycle the write strobe was active. Values presented in the cycle the strobe ends, or later, have no effect.
- R3: The write strobe is active when ce_n = 0, we_n = 0 and oe_n = 1. A load happens in the first sampled cycle after the strobe is active in which the strobe is inactive and oe_n = 1.
- R4: Every accepted load restarts the load window. The commit starts LOAD_CYC cycles after the last accepted load, so any number of bytes spaced closer than that all land in one page.
- R5: A commit writes only the columns loaded in its window, from 1 up to the whole page (2^COL_W bytes). A column loaded twice keeps its later value. All other bytes of the row keep their old values.
- R6: A commit lasts max(PROG_CYC, 2^COL_W) cycles. Afterwards the page register is empty, so no byte from an earlier window is written again.
- R7: While a window or commit is open, a read returns bit 7 = NOT bit 7 of the last accepted byte and bits 5..0 = 0. Bit 6 is cleared by the load that opens a window and inverts at the start of each read (reads 1, 0, 1, ...).
- R8: Once the commit ends, reads return true array data.
- R9: Inside a window, a load whose row differs from the window's row is ignored.
- R10: Loads that arrive during a commit are ignored and open no window.
- R11: While wr_inhibit = 1, every load, including command loads, is ignored.
- R12: The load sequence (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0) turns software protection on and admits the loads of the next window. The sequence (0x555,0xAA), (0x2AA,0x55), (0x555,0x20) turns it off. Command loads are never stored. While protection is on, plain loads are ignored and open no window. Protection is off after reset.
- R13: dout_oe is 1 exactly in the cycle after a cycle with ce_n = 0, oe_n = 0, we_n = 1. dout then holds that read's value. After reset dout_oe = 0 and dout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all host pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_inhibit | input | 1 | Hardware write block, active high |
| addr | input | ADDR_W | Byte address {row, column} |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 1 | Read data valid / drive enable |

## Verification
Most wrong internal states are invisible until a commit ends. A lost restart of the window, a stale page-register valid bit or a wrong latched row all show up as wrong array bytes on the first read after completion, which comes roughly LOAD_CYC plus the commit length after the last load. A wrong phase or toggle state shows up sooner, on the very next read. That read returns status where data was due (or the reverse), or bit 6 fails to alternate. The bench places one read a few cycles before and one a few cycles after the predicted end of a commit, so a timer that is off by more than that margin fails a check.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/eep_bus_if.sv
// Host strobe sampling, load-event detection and address/data capture.
module eep_bus_if #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              load_ev,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data,
  output logic              rd_act,
  output logic              rd_start,
  output logic              rd_held
);

  logic              wr_now;
  logic              wr_q;
  logic              rd_q;
  logic [ADDR_W-1:0] a_lat_q, a_lat_d;
  logic [7:0]        d_lat_q, d_lat_d;

  always_comb begin
    wr_now  = ~ce_n & ~we_n & oe_n;
    rd_act  = ~ce_n & ~oe_n & we_n;
    a_lat_d = wr_now ? addr : a_lat_q;
    d_lat_d = wr_now ? din  : d_lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      a_lat_q <= '0;
      d_lat_q <= '0;
    end else begin
      wr_q    <= wr_now;
      rd_q    <= rd_act;
      a_lat_q <= a_lat_d;
      d_lat_q <= d_lat_d;
    end
  end

  assign load_ev  = wr_q & ~wr_now & oe_n;
  assign ld_addr  = a_lat_q;
  assign ld_data  = d_lat_q;
  assign rd_start = rd_act & ~rd_q;
  assign rd_held  = rd_q;

endmodule

// File: rtl/eep_cmd_seq.sv
// Software write-protection command recogniser.
module eep_cmd_seq #(
  parameter int unsigned     ADDR_W = 11,
  parameter logic [ADDR_W-1:0] KEY_A = '0,
  parameter logic [ADDR_W-1:0] KEY_B = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic              gate,
  input  logic              win_end,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  output logic              cmd_hit,
  output logic              wr_allow
);

  logic [1:0] step_q, step_d;
  logic       prot_q, prot_d;
  logic       unlock_q, unlock_d;
  logic       ev, m_pre1, m_pre2, m_on, m_off;

  always_comb begin
    ev     = load_ev & ~gate;
    m_pre1 = (ld_addr == KEY_A) && (ld_data == 8'hAA);
    m_pre2 = (ld_addr == KEY_B) && (ld_data == 8'h55);
    m_on   = (ld_addr == KEY_A) && (ld_data == 8'hA0);
    m_off  = (ld_addr == KEY_A) && (ld_data == 8'h20);
    cmd_hit = ev & (((step_q == 2'd0) & m_pre1) |
                    ((step_q == 2'd1) & m_pre2) |
                    ((step_q == 2'd2) & (m_on | m_off)));
    step_d   = step_q;
    prot_d   = prot_q;
    unlock_d = unlock_q;
    if (win_end) unlock_d = 1'b0;
    if (ev) begin
      if (!cmd_hit)            step_d = 2'd0;
      else if (step_q == 2'd2) step_d = 2'd0;
      else                     step_d = step_q + 2'd1;
      if (cmd_hit && step_q == 2'd2) begin
        prot_d   = m_on;
        unlock_d = m_on;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      prot_q   <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      prot_q   <= prot_d;
      unlock_q <= unlock_d;
    end
  end

  assign wr_allow = ~prot_q | unlock_q;

endmodule

// File: rtl/eep_page_buf.sv
// Page register: one data byte and one loaded flag per column.
module eep_page_buf #(
  parameter int unsigned COL_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [COL_W-1:0]         wr_col,
  input  logic [7:0]               wr_data,
  input  logic                     clr,
  input  logic [COL_W-1:0]         rd_col,
  output logic [7:0]               rd_data,
  output logic [(1<<COL_W)-1:0]    valid
);

  localparam int unsigned PAGE_BYTES = 1 << COL_W;

  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q, valid_d;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    assign valid_d[g] = ~clr & (valid_q[g] | (wr_en & (wr_col == COL_W'(g))));
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_col] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign rd_data = data_q[rd_col];
  assign valid   = valid_q;

endmodule

// File: rtl/eep_page_ctrl.sv
// Top: load window, self-timed commit, storage array and read/status path.
module eep_page_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned COL_W      = 6,
  parameter int unsigned LOAD_CYC   = 40,
  parameter int unsigned PROG_CYC   = 150,
  parameter int unsigned CMD_ADDR_A = 32'h555,
  parameter int unsigned CMD_ADDR_B = 32'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wr_inhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);

  localparam int unsigned ROW_W      = ADDR_W - COL_W;
  localparam int unsigned PAGE_BYTES = 1 << COL_W;
  localparam int unsigned DEPTH      = 1 << ADDR_W;
  localparam int unsigned PROG_LEN   = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
  localparam int unsigned CNT_MAX    = (LOAD_CYC > PROG_LEN) ? LOAD_CYC : PROG_LEN;
  localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_LEN - 1);
  localparam logic [ADDR_W-1:0] KEY_A = CMD_ADDR_A[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] KEY_B = CMD_ADDR_B[ADDR_W-1:0];

  // host interface
  logic              load_ev, rd_act, rd_start, rd_held;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data;
  logic [ROW_W-1:0]  ld_row;
  logic [COL_W-1:0]  ld_col;

  eep_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .load_ev(load_ev), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_act(rd_act), .rd_start(rd_start), .rd_held(rd_held)
  );

  assign ld_row = ld_addr[ADDR_W-1:COL_W];
  assign ld_col = ld_addr[COL_W-1:0];

  // state
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             last7_q, last7_d;
  logic             tog_q, tog_d;
  logic [7:0]       dout_q, dout_d;

  logic gate, cmd_hit, wr_allow, accept, prog_done, busy, commit_we;
  logic [COL_W-1:0]      ccol;
  logic [7:0]            pg_rd_data;
  logic [PAGE_BYTES-1:0] pg_valid;

  assign gate      = wr_inhibit | (phase_q == PH_PROG);
  assign prog_done = (phase_q == PH_PROG) && (cnt_q == PROG_LAST);
  assign busy      = (phase_q != PH_IDLE);

  eep_cmd_seq #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .gate(gate),
    .win_end(prog_done), .ld_addr(ld_addr), .ld_data(ld_data),
    .cmd_hit(cmd_hit), .wr_allow(wr_allow)
  );

  assign accept = load_ev & ~gate & ~cmd_hit & wr_allow &
                  ((phase_q == PH_IDLE) | (ld_row == row_q));

  // commit walks one column per cycle during the first PAGE_BYTES cycles
  assign ccol      = cnt_q[COL_W-1:0];
  assign commit_we = (phase_q == PH_PROG) && (cnt_q < CNT_W'(PAGE_BYTES)) && pg_valid[ccol];

  eep_page_buf #(.COL_W(COL_W)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_col(ld_col),
    .wr_data(ld_data), .clr(prog_done), .rd_col(ccol),
    .rd_data(pg_rd_data), .valid(pg_valid)
  );

  // storage array
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit_we) mem[{row_q, ccol}] <= pg_rd_data;
  end

  // phase sequencing
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    row_d   = row_q;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_LOAD;
        cnt_d   = '0;
        row_d   = ld_row;
      end
      PH_LOAD: begin
        if (accept) begin
          cnt_d = '0;
        end else if (cnt_q == LOAD_LAST) begin
          phase_d = PH_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_PROG: begin
        if (prog_done) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // status and read path
  always_comb begin
    last7_d = accept ? ld_data[7] : last7_q;
    tog_d   = tog_q;
    if ((phase_q == PH_IDLE) && accept) tog_d = 1'b0;
    else if (busy && rd_start)          tog_d = ~tog_q;
    dout_d = dout_q;
    if (rd_act) dout_d = busy ? {~last7_q, tog_d, 6'b000000} : mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      last7_q <= 1'b0;
      tog_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      row_q   <= row_d;
      last7_q <= last7_d;
      tog_q   <= tog_d;
      dout_q  <= dout_d;
    end
  end

  assign dout    = dout_q;
  assign dout_oe = rd_held;

endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk
  import eep_pkg::*;
#(
  parameter int unsigned ROW_W      = 5,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned CNT_MAX    = 150
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ce_n,
  input logic                  oe_n,
  input logic                  we_n,
  input logic                  wr_inhibit,
  input logic [7:0]            dout,
  input logic                  dout_oe,
  input phase_e                phase_q,
  input logic [ROW_W-1:0]      row_q,
  input logic [PAGE_BYTES-1:0] pg_valid,
  input logic                  last7_q,
  input logic [CNT_W-1:0]      cnt_q
);

  AST_OE_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dout_oe == $past(!ce_n && !oe_n && we_n))); // R13

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(row_q)); // R9

  AST_PROG_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PROG) |=> ((pg_valid == $past(pg_valid)) || (pg_valid == '0))); // R10

  AST_PAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_IDLE) && ($past(phase_q) == PH_PROG)) |-> (pg_valid == '0)); // R6

  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && (phase_q != PH_PROG)) |=> $stable(pg_valid)); // R11

  AST_STATUS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && ($past(phase_q) != PH_IDLE)) |-> (dout[7] == !$past(last7_q))); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CNT_W'(CNT_MAX))); // R4

endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
  .ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .wr_inhibit(wr_inhibit), .dout(dout), .dout_oe(dout_oe),
  .phase_q(phase_q), .row_q(row_q), .pg_valid(pg_valid),
  .last7_q(last7_q), .cnt_q(cnt_q)
);

// File: tb/tb_eep_page_ctrl.sv
module tb_eep_page_ctrl;

  localparam int ADDR_W   = 11;
  localparam int COL_W    = 6;
  localparam int LOAD_CYC = 40;
  localparam int PROG_CYC = 150;
  localparam int PROG_LEN = 150;
  localparam int SETTLE   = LOAD_CYC + PROG_LEN + 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, oe_n, we_n, wr_inhibit;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        din;
  logic [7:0]        dout;
  logic              dout_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eep_page_ctrl #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC),
    .CMD_ADDR_A(32'h555), .CMD_ADDR_B(32'h2AA)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_inhibit(wr_inhibit), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;

  item_t sb_q[$];
  item_t it;
  event  sample_ev;

  function automatic logic [ADDR_W-1:0] mk(input int row, input int col);
    return ADDR_W'(row * 64 + col);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each sampled read against the queued item
  always begin
    @(sample_ev);
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      chk(dout_oe == 1'b1, {it.tag, " oe"}, int'(dout_oe), 1);
      chk((dout & it.mask) == (it.exp & it.mask), it.tag,
          int'(dout & it.mask), int'(it.exp & it.mask));
    end
  end

  task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; addr = ~a; din = ~d;   // R2: changed at strobe end
    @(negedge clk);
  endtask

  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [7:0] e,
                        input logic [7:0] m, input string tag);
    item_t n;
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    #1;
    n.exp = e; n.mask = m; n.tag = tag;
    sb_q.push_back(n);
    -> sample_ev;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic settle();
    repeat (SETTLE) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    wr_inhibit = 1'b0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(dout_oe == 1'b0, "R13 reset oe", int'(dout_oe), 0);
    chk(dout == 8'h00, "R13 reset dout", int'(dout), 0);

    // R1 R3 R5: full page on row 3
    for (int c = 0; c < 64; c++) wr_byte(mk(3, c), 8'(c * 3 + 7));
    settle();
    for (int c = 0; c < 64; c++) rd_exp(mk(3, c), 8'(c * 3 + 7), 8'hFF, "R1 full page");
    @(negedge clk);
    chk(dout_oe == 1'b0, "R13 oe idle", int'(dout_oe), 0);

    // seed row 4
    wr_byte(mk(4, 0), 8'h3C);
    wr_byte(mk(4, 1), 8'h3D);
    settle();

    // R5 partial page, R9 foreign row ignored
    wr_byte(mk(3, 5), 8'h11);
    wr_byte(mk(4, 0), 8'h99);
    wr_byte(mk(3, 5), 8'hA5);
    settle();
    rd_exp(mk(3, 5), 8'hA5, 8'hFF, "R5 rewritten column");
    rd_exp(mk(3, 4), 8'd19, 8'hFF, "R5 neighbour kept");
    rd_exp(mk(3, 6), 8'd25, 8'hFF, "R5 neighbour kept");
    rd_exp(mk(4, 0), 8'h3C, 8'hFF, "R9 other row ignored");

    // R7 status, R10 load during commit, R8 data after completion
    wr_byte(mk(4, 1), 8'hC5);
    rd_exp(mk(4, 1), 8'h40, 8'hFF, "R7 status read 1");
    rd_exp(mk(4, 1), 8'h00, 8'hFF, "R7 status read 2");
    rd_exp(mk(4, 1), 8'h40, 8'hFF, "R7 status read 3");
    repeat (LOAD_CYC + 10) @(posedge clk);
    wr_byte(mk(4, 0), 8'h11);
    rd_exp(mk(4, 0), 8'h00, 8'hFF, "R7 status in commit");
    settle();
    rd_exp(mk(4, 1), 8'hC5, 8'hFF, "R8 data after commit");
    rd_exp(mk(4, 0), 8'h3C, 8'hFF, "R10 load in commit ignored");
    rd_exp(mk(4, 0), 8'h3C, 8'hFF, "R10 no late window");

    // R6 page register cleared between windows
    wr_byte(mk(6, 1), 8'h01);
    settle();
    wr_byte(mk(7, 1), 8'h5A);
    settle();
    wr_byte(mk(6, 3), 8'h33);
    settle();
    rd_exp(mk(6, 1), 8'h01, 8'hFF, "R6 stale byte not rewritten");
    rd_exp(mk(6, 3), 8'h33, 8'hFF, "R6 new byte");

    // R4 window restart and commit end timing
    for (int i = 0; i < 8; i++) begin
      wr_byte(mk(7, 10 + i), 8'(8'h80 + i));
      if (i != 7) repeat (27) @(posedge clk);
    end
    repeat (180) @(posedge clk);
    rd_exp(mk(7, 17), 8'h00, 8'h80, "R4 still busy before end");
    repeat (12) @(posedge clk);
    rd_exp(mk(7, 17), 8'h87, 8'hFF, "R6 done after commit length");
    for (int i = 0; i < 8; i++) rd_exp(mk(7, 10 + i), 8'(8'h80 + i), 8'hFF, "R4 spaced loads");

    // R11 hardware inhibit
    wr_inhibit = 1'b1;
    wr_byte(mk(3, 0), 8'hEE);
    rd_exp(mk(3, 0), 8'd7, 8'hFF, "R11 no window opened");
    settle();
    rd_exp(mk(3, 0), 8'd7, 8'hFF, "R11 inhibited write");
    wr_inhibit = 1'b0;

    // R12 software protection
    wr_byte(ADDR_W'(11'h555), 8'hAA);
    wr_byte(ADDR_W'(11'h2AA), 8'h55);
    wr_byte(ADDR_W'(11'h555), 8'hA0);
    rd_exp(mk(3, 3), 8'd16, 8'hFF, "R12 command opens no window");
    wr_byte(mk(3, 1), 8'h42);
    settle();
    rd_exp(mk(3, 1), 8'h42, 8'hFF, "R12 unlocked write");
    wr_byte(mk(3, 2), 8'h24);
    rd_exp(mk(3, 2), 8'd13, 8'hFF, "R12 protected no window");
    settle();
    rd_exp(mk(3, 2), 8'd13, 8'hFF, "R12 protected write ignored");
    wr_byte(ADDR_W'(11'h555), 8'hAA);
    wr_byte(ADDR_W'(11'h2AA), 8'h55);
    wr_byte(ADDR_W'(11'h555), 8'h20);
    wr_byte(mk(3, 2), 8'h24);
    settle();
    rd_exp(mk(3, 2), 8'h24, 8'hFF, "R12 protection off");

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule